// File: doc/BRIEF.md
# Reset Qualification and Stretch Sequencer

This block turns a noisy, asynchronous, active-low reset pin into one clean internal reset pulse for the logic around it. The pin first passes through a two-flop synchronizer. A low level then has to stay low for a minimum number of consecutive clocks before it counts as a real reset. That minimum is long for the first reset after power is applied and short for every later one. Once a reset qualifies, the internal reset stays high while the pin is low. It then stays high for a fixed stretch after the pin is released. If the pin dips low again during that stretch, the stretch starts over, so ripple on a slow rising edge never splits the reset into several pulses.

While the internal reset is high, the block also gates the pad-side controls of the surrounding core. Bidirectional data drivers are disabled. Active-low outputs are held high. Active-high outputs and the strobe are held low. The serial output is held high. An automatic polarity-correction enable flag is cleared and cannot be written. A synchronous active-high `pwr_up` input models the application of power: it re-arms the long first-reset requirement.

Top module: `rst_qualifier`

## Requirements
- R1: The pin is sampled through a two-flop synchronizer. A pin held low during clock edges 1..L is seen by the sequencer at edges 3..L+2.
- R2: After `pwr_up`, no reset has completed yet. In that state `core_rst` asserts only if the pin is low for at least COLD_MIN (3000) consecutive edges. It rises on edge COLD_MIN+2 counted from the first low edge.
- R3: After a reset has completed, WARM_MIN (80) consecutive low edges are enough. `core_rst` rises on edge WARM_MIN+2.
- R4: A low pulse shorter than the minimum that applies is ignored. `core_rst` stays low, and the power-up state is not cleared, so the next reset still needs the long minimum.
- R5: If R is the first edge at which the pin is high again, `core_rst` falls on edge R+HOLD+2 (HOLD=10). Every internal reset pulse therefore lasts at least HOLD+1 clocks.
- R6: A pin low during the post-release hold keeps `core_rst` high and restarts the hold count. It never produces a second rising edge of `core_rst`.
- R7: While `core_rst` is high, the pad controls are forced: `pad_data_oe`=0, `pad_act_lo` all ones, `pad_act_hi`=0, `pad_strobe`=0, `pad_ser`=1. While it is low, each pad control equals its core input.
- R8: `pol_en` is cleared by `core_rst` and by `pwr_up`. `pol_wr` is ignored while `core_rst` is high. Otherwise `pol_wr` loads `pol_wdata` on the next edge.
- R9: `pwr_up` (synchronous, active high) leaves `core_rst` low, the synchronizer in the released state, and the power-up state set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_up | input | 1 | Synchronous power-application reset, active high |
| rst_pin_n | input | 1 | Asynchronous external reset pin, active low |
| core_rst | output | 1 | Qualified, stretched internal reset, active high |
| core_data_oe | input | 1 | Core request to drive bidirectional data |
| core_act_lo | input | N_LO | Core values for active-low outputs |
| core_act_hi | input | N_HI | Core values for active-high outputs |
| core_strobe | input | 1 | Core value for the strobe output |
| core_ser | input | 1 | Core value for the serial output |
| pol_wr | input | 1 | Write strobe for the polarity-correction enable |
| pol_wdata | input | 1 | Value written to the polarity-correction enable |
| pad_data_oe | output | 1 | Gated bidirectional output enable |
| pad_act_lo | output | N_LO | Gated active-low outputs |
| pad_act_hi | output | N_HI | Gated active-high outputs |
| pad_strobe | output | 1 | Gated strobe output |
| pad_ser | output | 1 | Gated serial output |
| pol_en | output | 1 | Polarity-correction enable flag |

## Verification
Several properties are checked on every cycle:
- every internal reset pulse lasts at least HOLD+1 clocks;
- a rising reset is always preceded by a synchronized low pin;
- a pin low during the hold keeps the reset high;
- the pads are forced and the polarity flag cleared whenever reset is high;
- a completed reset clears the power-up state.

Only the bench scenarios can show the exact qualification lengths for cold and warm resets, the rejection of short pulses without losing the power-up state, the single pulse produced by a rippling release, and the exact rise and fall edges.

// File: rtl/rstq_pkg.sv
package rstq_pkg;

    typedef enum logic [1:0] {
        ST_WATCH  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HOLD   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic data_oe;
        logic strobe;
        logic ser;
    } pad_bits_t;

    // Minimum qualified low length for the current power state
    function automatic int unsigned need_len(input logic cold,
                                             input int unsigned cold_min,
                                             input int unsigned warm_min);
        return cold ? cold_min : warm_min;
    endfunction

endpackage

// File: rtl/rstq_sync.sv
module rstq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pwr_up,
    input  logic pin_n,
    output logic pin_lo
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (pwr_up) begin
            chain <= '1;
        end else begin
            chain[0] <= pin_n;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign pin_lo = ~chain[STAGES-1];
endmodule

// File: rtl/rstq_seq.sv
module rstq_seq
    import rstq_pkg::*;
#(
    parameter int unsigned COLD_MIN = 3000,
    parameter int unsigned WARM_MIN = 80,
    parameter int unsigned HOLD     = 10
) (
    input  logic clk,
    input  logic pwr_up,
    input  logic pin_lo,
    output logic rst_out,
    output logic cold
);
    localparam int QW = $clog2(COLD_MIN + 1);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] HOLD_END = HW'(HOLD);

    seq_state_e st;
    logic [QW-1:0] q_cnt;
    logic [HW-1:0] h_cnt;
    logic [QW-1:0] q_last;

    assign q_last = QW'(need_len(cold, COLD_MIN, WARM_MIN) - 1);

    always_ff @(posedge clk) begin
        if (pwr_up) begin
            st      <= ST_WATCH;
            q_cnt   <= '0;
            h_cnt   <= '0;
            cold    <= 1'b1;
            rst_out <= 1'b0;
        end else begin
            case (st)
                ST_WATCH: begin
                    if (pin_lo) begin
                        if (q_cnt == q_last) begin
                            st      <= ST_ACTIVE;
                            rst_out <= 1'b1;
                            q_cnt   <= '0;
                        end else begin
                            q_cnt <= q_cnt + 1'b1;
                        end
                    end else begin
                        q_cnt <= '0;
                    end
                end
                ST_ACTIVE: begin
                    if (!pin_lo) begin
                        st    <= ST_HOLD;
                        h_cnt <= HW'(1);
                    end
                end
                ST_HOLD: begin
                    if (pin_lo) begin
                        st <= ST_ACTIVE;
                    end else if (h_cnt == HOLD_END) begin
                        st      <= ST_WATCH;
                        rst_out <= 1'b0;
                        cold    <= 1'b0;
                        h_cnt   <= '0;
                    end else begin
                        h_cnt <= h_cnt + 1'b1;
                    end
                end
                default: st <= ST_WATCH;
            endcase
        end
    end

    // Width monitor for the pulse-length check
    logic [15:0] hi_run;
    always_ff @(posedge clk) begin
        if (pwr_up || !rst_out) hi_run <= '0;
        else if (hi_run != 16'hFFFF) hi_run <= hi_run + 1'b1;
    end

    assert_min_width_R5: assert property (@(posedge clk) disable iff (pwr_up)
        $fell(rst_out) |-> $past(hi_run) >= 16'(HOLD));

    assert_rise_needs_pin_R4: assert property (@(posedge clk) disable iff (pwr_up)
        $rose(rst_out) |-> $past(pin_lo));

    assert_hold_restart_R6: assert property (@(posedge clk) disable iff (pwr_up)
        (st == ST_HOLD && pin_lo) |=> rst_out);

    assert_cold_clears_R2: assert property (@(posedge clk) disable iff (pwr_up)
        $fell(rst_out) |-> !cold);

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (pwr_up)
        q_cnt <= QW'(COLD_MIN));
endmodule

// File: rtl/rstq_outgate.sv
module rstq_outgate
    import rstq_pkg::*;
#(
    parameter int N_LO = 4,
    parameter int N_HI = 4
) (
    input  logic            clk,
    input  logic            pwr_up,
    input  logic            rst_in,
    input  pad_bits_t       core_bits,
    input  logic [N_LO-1:0] core_lo,
    input  logic [N_HI-1:0] core_hi,
    input  logic            pol_wr,
    input  logic            pol_wdata,
    output pad_bits_t       pad_bits,
    output logic [N_LO-1:0] pad_lo,
    output logic [N_HI-1:0] pad_hi,
    output logic            pol_en
);
    always_comb begin
        if (rst_in) begin
            pad_bits.data_oe = 1'b0;
            pad_bits.strobe  = 1'b0;
            pad_bits.ser     = 1'b1;
            pad_lo           = '1;
            pad_hi           = '0;
        end else begin
            pad_bits = core_bits;
            pad_lo   = core_lo;
            pad_hi   = core_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (pwr_up || rst_in) pol_en <= 1'b0;
        else if (pol_wr)      pol_en <= pol_wdata;
    end

    assert_pads_idle_R7: assert property (@(posedge clk) disable iff (pwr_up)
        rst_in |-> (!pad_bits.data_oe && !pad_bits.strobe && pad_bits.ser
                    && (&pad_lo) && !(|pad_hi)));

    assert_pol_cleared_R8: assert property (@(posedge clk) disable iff (pwr_up)
        rst_in |=> !pol_en);
endmodule

// File: rtl/rst_qualifier.sv
module rst_qualifier
    import rstq_pkg::*;
#(
    parameter int unsigned COLD_MIN = 3000,
    parameter int unsigned WARM_MIN = 80,
    parameter int unsigned HOLD     = 10,
    parameter int          N_LO     = 4,
    parameter int          N_HI     = 4
) (
    input  logic            clk,
    input  logic            pwr_up,
    input  logic            rst_pin_n,
    output logic            core_rst,
    input  logic            core_data_oe,
    input  logic [N_LO-1:0] core_act_lo,
    input  logic [N_HI-1:0] core_act_hi,
    input  logic            core_strobe,
    input  logic            core_ser,
    input  logic            pol_wr,
    input  logic            pol_wdata,
    output logic            pad_data_oe,
    output logic [N_LO-1:0] pad_act_lo,
    output logic [N_HI-1:0] pad_act_hi,
    output logic            pad_strobe,
    output logic            pad_ser,
    output logic            pol_en
);
    logic      pin_lo;
    logic      cold;
    pad_bits_t cbits;
    pad_bits_t pbits;

    rstq_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .pwr_up (pwr_up),
        .pin_n  (rst_pin_n),
        .pin_lo (pin_lo)
    );

    rstq_seq #(.COLD_MIN(COLD_MIN), .WARM_MIN(WARM_MIN), .HOLD(HOLD)) u_seq (
        .clk     (clk),
        .pwr_up  (pwr_up),
        .pin_lo  (pin_lo),
        .rst_out (core_rst),
        .cold    (cold)
    );

    assign cbits.data_oe = core_data_oe;
    assign cbits.strobe  = core_strobe;
    assign cbits.ser     = core_ser;

    rstq_outgate #(.N_LO(N_LO), .N_HI(N_HI)) u_gate (
        .clk       (clk),
        .pwr_up    (pwr_up),
        .rst_in    (core_rst),
        .core_bits (cbits),
        .core_lo   (core_act_lo),
        .core_hi   (core_act_hi),
        .pol_wr    (pol_wr),
        .pol_wdata (pol_wdata),
        .pad_bits  (pbits),
        .pad_lo    (pad_act_lo),
        .pad_hi    (pad_act_hi),
        .pol_en    (pol_en)
    );

    assign pad_data_oe = pbits.data_oe;
    assign pad_strobe  = pbits.strobe;
    assign pad_ser     = pbits.ser;

    // Power-up state is re-armed by pwr_up and never by the pin
    assert_cold_rearm_R9: assert property (@(posedge clk)
        pwr_up |=> (cold && !core_rst));
endmodule

// File: tb/test_rst_qualifier.sv
module test_rst_qualifier;
    localparam int COLD = 3000;
    localparam int WARM = 80;
    localparam int HOLD = 10;
    localparam int NV   = 9;
    // Vector table: apply pwr_up first (1/0), pin low length in edges
    localparam int V_PWR [NV] = '{1, 0, 0, 0, 0, 0, 1, 0, 0};
    localparam int V_LEN [NV] = '{2999, 79, 3000, 79, 80, 250, 80, 3000, 1};

    logic clk = 0;
    logic pwr_up = 0, rst_pin_n = 1;
    logic core_data_oe = 0, core_strobe = 0, core_ser = 0;
    logic [3:0] core_act_lo = 4'h0, core_act_hi = 4'h0;
    logic pol_wr = 0, pol_wdata = 0;
    logic core_rst, pad_data_oe, pad_strobe, pad_ser, pol_en;
    logic [3:0] pad_act_lo, pad_act_hi;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    bit cold_m = 1;

    always #10 clk = ~clk;

    rst_qualifier i_rst_qualifier (
        .clk(clk), .pwr_up(pwr_up), .rst_pin_n(rst_pin_n), .core_rst(core_rst),
        .core_data_oe(core_data_oe), .core_act_lo(core_act_lo),
        .core_act_hi(core_act_hi), .core_strobe(core_strobe), .core_ser(core_ser),
        .pol_wr(pol_wr), .pol_wdata(pol_wdata), .pad_data_oe(pad_data_oe),
        .pad_act_lo(pad_act_lo), .pad_act_hi(pad_act_hi), .pad_strobe(pad_strobe),
        .pad_ser(pad_ser), .pol_en(pol_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_pwr_up();
        @(negedge clk); pwr_up = 1; rst_pin_n = 1;
        @(negedge clk); pwr_up = 0;
        cold_m = 1;
    endtask

    // Pin low for edges 1..len; report first cycle reset seen and high count
    task automatic pulse(input int len, output int rise, output int hi);
        rise = 0; hi = 0;
        @(negedge clk); rst_pin_n = 0;
        for (int c = 1; c <= len + HOLD + 10; c++) begin
            @(negedge clk);
            if (c == len) rst_pin_n = 1;
            if (core_rst) begin
                hi++;
                if (rise == 0) rise = c;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int rise, hi, need;
        do_pwr_up();
        // R9: state right after power-up
        check("R9 core_rst after pwr_up", core_rst, 0);
        check("R8 pol_en after pwr_up", pol_en, 0);
        check("R7 pad_ser passes core", pad_ser, 0);

        for (int v = 0; v < NV; v++) begin
            if (V_PWR[v] != 0) do_pwr_up();
            need = cold_m ? COLD : WARM;
            pulse(V_LEN[v], rise, hi);
            if (V_LEN[v] >= need) begin
                // R1 R2 R3: rise on edge need+2; R5: width len+HOLD-need+1
                check(cold_m ? "R2 cold rise edge" : "R3 warm rise edge", rise, need + 2);
                check("R5 pulse width", hi, V_LEN[v] + HOLD - need + 1);
                cold_m = 0;
            end else begin
                check("R4 short pulse ignored", hi, 0);
            end
        end

        // R6: ripple during hold restarts it, single pulse
        begin
            int rises = 0, last = 0;
            logic prev = 0;
            @(negedge clk); rst_pin_n = 0;
            for (int c = 1; c <= 140; c++) begin
                @(negedge clk);
                rst_pin_n = ((c + 1 <= 100) || (c + 1 >= 106 && c + 1 <= 107)) ? 1'b0 : 1'b1;
                if (core_rst && !prev) rises++;
                if (core_rst) last = c;
                prev = core_rst;
            end
            check("R6 single rise", rises, 1);
            check("R6 hold restart fall", last, 108 + HOLD + 1);
        end

        // R7 R8: gating during reset and polarity flag handling
        core_data_oe = 1; core_act_lo = 4'h0; core_act_hi = 4'hF;
        core_strobe = 1; core_ser = 0;
        @(negedge clk); rst_pin_n = 0;
        repeat (90) @(negedge clk);
        check("R7 core_rst during low", core_rst, 1);
        check("R7 data_oe forced", pad_data_oe, 0);
        check("R7 act_lo forced", pad_act_lo, 4'hF);
        check("R7 act_hi forced", pad_act_hi, 0);
        check("R7 strobe forced", pad_strobe, 0);
        check("R7 ser forced", pad_ser, 1);
        pol_wr = 1; pol_wdata = 1;
        @(negedge clk); pol_wr = 0;
        check("R8 write ignored in reset", pol_en, 0);
        rst_pin_n = 1;
        repeat (20) @(negedge clk);
        check("R7 data_oe passes", pad_data_oe, 1);
        check("R7 act_lo passes", pad_act_lo, 0);
        check("R7 act_hi passes", pad_act_hi, 4'hF);
        check("R7 strobe passes", pad_strobe, 1);
        pol_wr = 1; pol_wdata = 1;
        @(negedge clk); pol_wr = 0;
        check("R8 write loads", pol_en, 1);
        pulse(WARM, rise, hi);
        check("R8 cleared by reset", pol_en, 0);
        pol_wr = 1; pol_wdata = 1;
        @(negedge clk); pol_wr = 0;
        do_pwr_up();
        check("R8 cleared by pwr_up", pol_en, 0);
        // R9: after pwr_up the long minimum applies again
        pulse(WARM, rise, hi);
        check("R9 warm length rejected after pwr_up", hi, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule